// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block maps a flat virtual address space onto physical device addresses through four programmable windows. Windows 0, 2 and 3 front memory regions, and window 1 fronts a register region. In virtual space the windows sit back to back in index order. Window 0 begins at virtual address 0. Each later window begins where the one before it ends. Window 3 has no size, so it takes every virtual address at or above the end of window 2.

Software sets up the windows through a write port with a 3-bit slot select and a data word. Windows 0 to 2 each have a physical start and a size, and window 3 has a start only. Each request carries a virtual address. One cycle later the block returns the physical address, the index of the window that matched, and a hit flag. The hit flag clears when the translated address does not fit in the physical address width.

Top module: `addr_window_xlate`

## Requirements
- R1: While reset is asserted, and after it until the first request, rsp_valid, rsp_paddr, rsp_win and rsp_hit are all zero.
- R2: A virtual address v below size0 returns window 0 with physical address start0 + v.
- R3: A virtual address v with size0 <= v < size0+size1 returns window 1 with physical address start1 + (v - size0).
- R4: A virtual address v with size0+size1 <= v < size0+size1+size2 returns window 2 with physical address start2 + (v - size0 - size1).
- R5: A virtual address v at or above size0+size1+size2 returns window 3 with physical address start3 + (v - size0 - size1 - size2). The window has no upper bound.
- R6: A window of size zero covers no address. Its neighbours meet exactly, so the address where it would begin goes to the next window with a nonzero size.
- R7: rsp_valid is req_valid delayed by exactly one cycle. rsp_paddr, rsp_win and rsp_hit hold their values in any cycle with no request.
- R8: Slot select codes are: 0 start0, 1 size0, 2 start1, 3 size1, 4 start2, 5 size2, 6 start3. A write with code 7 changes nothing. A request in the same cycle as a write uses the old settings, and the write applies from the next request on.
- R9: rsp_hit is 1 when start + offset fits in the address width. When the sum carries out, rsp_hit is 0 and rsp_paddr carries the low address bits.
- R10: Reset sets every start and size to zero, so after reset any address v goes to window 3 with physical address v.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration slot select |
| cfg_data | input | AW | Configuration value |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | AW | Virtual address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_paddr | output | AW | Translated physical address |
| rsp_win | output | 2 | Index of the matched window |
| rsp_hit | output | 1 | Translation fits in the physical space |

## Verification
The main test runs addresses placed on both sides of every window edge: the first and last address of windows 0 to 2, the first address of window 3, and addresses far into window 3. These show whether each comparison uses `<` or `<=` and whether each offset uses the right base. One address deep in window 3 pushes the sum past the address width, which separates a correct hit flag from one that is always set. Directed cases then shrink a window to zero size, write to the unused slot code, and issue a write and a request in the same cycle. These show whether empty windows are skipped, whether stray writes are ignored, and when a new setting takes effect.

// File: rtl/addr_window_xlate.sv
module addr_window_xlate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic [1:0]    rsp_win,
  output logic          rsp_hit
);
  localparam int EW = AW + 2;

  logic [AW-1:0] st0, st1, st2, st3;
  logic [AW-1:0] sz0, sz1, sz2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st0 <= '0; st1 <= '0; st2 <= '0; st3 <= '0;
      sz0 <= '0; sz1 <= '0; sz2 <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: st0 <= cfg_data;
        3'd1: sz0 <= cfg_data;
        3'd2: st1 <= cfg_data;
        3'd3: sz1 <= cfg_data;
        3'd4: st2 <= cfg_data;
        3'd5: sz2 <= cfg_data;
        3'd6: st3 <= cfg_data;
        default: ;
      endcase
    end
  end

  logic [EW-1:0] end0, end1, end2, vx;
  assign end0 = {2'b00, sz0};
  assign end1 = end0 + {2'b00, sz1};
  assign end2 = end1 + {2'b00, sz2};
  assign vx   = {2'b00, req_vaddr};

  logic [1:0]    win;
  logic [AW-1:0] base, start, off;
  logic [AW:0]   sum;

  always_comb begin
    if (vx < end0) begin
      win = 2'd0; base = '0;               start = st0;
    end else if (vx < end1) begin
      win = 2'd1; base = end0[AW-1:0];     start = st1;
    end else if (vx < end2) begin
      win = 2'd2; base = end1[AW-1:0];     start = st2;
    end else begin
      win = 2'd3; base = end2[AW-1:0];     start = st3;
    end
  end

  assign off = req_vaddr - base;
  assign sum = {1'b0, start} + {1'b0, off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_win   <= '0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= sum[AW-1:0];
        rsp_win   <= win;
        rsp_hit   <= ~sum[AW];
      end
    end
  end
endmodule

module addr_window_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic          req_valid,
  input logic [AW-1:0] req_vaddr,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_paddr,
  input logic [1:0]    rsp_win,
  input logic          rsp_hit,
  input logic [AW-1:0] c_sz0,
  input logic [AW-1:0] c_sz1,
  input logic [AW-1:0] c_sz2,
  input logic [AW-1:0] c_st0,
  input logic [AW-1:0] c_st3
);
  logic [AW+1:0] span;
  assign span = {2'b00, c_sz0} + {2'b00, c_sz1} + {2'b00, c_sz2};

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_paddr) && $stable(rsp_win) && $stable(rsp_hit)));

  // R2
  first_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr < c_sz0) |=> (rsp_win == 2'd0));

  // R5
  last_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && {2'b00, req_vaddr} >= span) |=> (rsp_win == 2'd3));

  // R8
  unused_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd7) |=> ($stable(c_sz0) && $stable(c_sz1) &&
      $stable(c_sz2) && $stable(c_st0) && $stable(c_st3)));
endmodule

bind addr_window_xlate addr_window_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .req_valid(req_valid), .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_win(rsp_win), .rsp_hit(rsp_hit),
  .c_sz0(sz0), .c_sz1(sz1), .c_sz2(sz2), .c_st0(st0), .c_st3(st3)
);

// File: tb/addr_window_xlate_tb.sv
module addr_window_xlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_vaddr = '0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_paddr;
  logic [1:0]    rsp_win;
  logic          rsp_hit;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_xlate #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_win(rsp_win), .rsp_hit(rsp_hit)
  );

  typedef struct packed {
    logic [7:0]    rq;
    logic [AW-1:0] va;
    logic [AW-1:0] pa;
    logic [1:0]    w;
    logic          h;
  } vec_t;

  // windows: start0=1000_0000 size0=100, start1=2000_0000 size1=80,
  //          start2=3000_0000 size2=40, start3=4000_0000 (window 3 from 1C0)
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 32'h0000_0000, 32'h1000_0000, 2'd0, 1'b1},   // R2 first
    '{8'd2, 32'h0000_00FF, 32'h1000_00FF, 2'd0, 1'b1},   // R2 last
    '{8'd3, 32'h0000_0100, 32'h2000_0000, 2'd1, 1'b1},   // R3 first
    '{8'd3, 32'h0000_017F, 32'h2000_007F, 2'd1, 1'b1},   // R3 last
    '{8'd4, 32'h0000_0180, 32'h3000_0000, 2'd2, 1'b1},   // R4 first
    '{8'd4, 32'h0000_01BF, 32'h3000_003F, 2'd2, 1'b1},   // R4 last
    '{8'd5, 32'h0000_01C0, 32'h4000_0000, 2'd3, 1'b1},   // R5 first
    '{8'd5, 32'h0000_1000, 32'h4000_0E40, 2'd3, 1'b1},   // R5 deep
    '{8'd5, 32'hBFFF_FFFF, 32'hFFFF_FE3F, 2'd3, 1'b1},   // R5 top without carry
    '{8'd9, 32'hFFFF_0000, 32'h3FFE_FE40, 2'd3, 1'b0}    // R9 carry out
  };

  task automatic chk(input int rq, input logic v, input logic [AW-1:0] pa,
                     input logic [1:0] w, input logic h);
    checks++;
    if (rsp_valid !== v || rsp_paddr !== pa || rsp_win !== w || rsp_hit !== h) begin
      fails++;
      $display("FAIL R%0d actual v=%b pa=%h w=%0d h=%b expected v=%b pa=%h w=%0d h=%b",
               rq, rsp_valid, rsp_paddr, rsp_win, rsp_hit, v, pa, w, h);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rq(input logic [AW-1:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(1, 1'b0, '0, 2'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after reset, before any request
    chk(1, 1'b0, '0, 2'd0, 1'b0);
    // R10 cleared configuration: identity through window 3
    rq(32'h0000_1234);
    chk(10, 1'b1, 32'h0000_1234, 2'd3, 1'b1);

    wr(3'd0, 32'h1000_0000);
    wr(3'd1, 32'h0000_0100);
    wr(3'd2, 32'h2000_0000);
    wr(3'd3, 32'h0000_0080);
    wr(3'd4, 32'h3000_0000);
    wr(3'd5, 32'h0000_0040);
    wr(3'd6, 32'h4000_0000);

    for (int i = 0; i < NV; i++) begin
      rq(VECS[i].va);
      chk(int'(VECS[i].rq), 1'b1, VECS[i].pa, VECS[i].w, VECS[i].h);
    end

    // R7 idle cycle: valid drops, data held
    @(negedge clk);
    chk(7, 1'b0, 32'h3FFE_FE40, 2'd3, 1'b0);

    // R8 unused code 7 changes nothing
    wr(3'd7, 32'hDEAD_BEEF);
    rq(32'h0000_0000);
    chk(8, 1'b1, 32'h1000_0000, 2'd0, 1'b1);
    rq(32'h0000_01C0);
    chk(8, 1'b1, 32'h4000_0000, 2'd3, 1'b1);

    // R8 write and request in the same cycle: old start applies
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_data = 32'h5000_0000;
    req_valid = 1'b1; req_vaddr = 32'h0000_0010;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(8, 1'b1, 32'h1000_0010, 2'd0, 1'b1);
    rq(32'h0000_0010);
    chk(8, 1'b1, 32'h5000_0010, 2'd0, 1'b1);

    // R6 zero-size window 1: 0x100 goes straight to window 2
    wr(3'd3, 32'h0000_0000);
    rq(32'h0000_0100);
    chk(6, 1'b1, 32'h3000_0000, 2'd2, 1'b1);
    rq(32'h0000_00FF);
    chk(6, 1'b1, 32'h5000_00FF, 2'd0, 1'b1);
    rq(32'h0000_0140);
    chk(6, 1'b1, 32'h4000_0000, 2'd3, 1'b1);

    // R7 back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_0001;
    @(negedge clk);
    chk(7, 1'b1, 32'h5000_0001, 2'd0, 1'b1);
    req_vaddr = 32'h0000_0120;
    @(negedge clk);
    req_valid = 1'b0;
    chk(7, 1'b1, 32'h3000_0020, 2'd2, 1'b1);

    // R10 reset again clears all windows
    rst_n = 1'b0;
    @(negedge clk);
    chk(1, 1'b0, '0, 2'd0, 1'b0);
    rst_n = 1'b1;
    rq(32'h0000_0010);
    chk(10, 1'b1, 32'h0000_0010, 2'd3, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule